// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a small programmable two-level sum-of-products fabric. Each primary input supplies both its true value and its complement as literals to an AND plane. The AND plane forms product lines, and an OR plane merges chosen product lines into each output. Once configured, the path from `din` to `dout` is purely combinational.

A single serial chain loads the connection bits for both planes. AND-plane bits go in first and OR-plane bits follow. Outputs stay at 0 until the loader signals completion, and any later shift clears that state again.

A `MODE` parameter selects one of three forms:
- **Full array:** both planes are programmable.
- **Fixed-OR:** the AND plane is programmable, and each output ORs a fixed, equal group of product lines.
- **Fixed-minterm:** the AND plane is a complete decoder with one line per input combination, and only the OR plane is programmable.

Top module: `sop_fabric`

## Requirements
- R1: Every input `din[i]` provides two literals to each product line: its true form (connection bit at polarity 0) and its complement (polarity 1). A product can use either literal.
- R2: An unconnected AND-plane crosspoint contributes logic 1 to its product. A product line with no connected literals is 0, so an unprogrammed term never asserts. A term that connects both literals of one input is always 0.
- R3: An unconnected OR-plane crosspoint contributes 0. An output with no connected product lines stays 0 for every input pattern.
- R4: Configuration bits enter on `cfgData` on each clock edge where `cfgShift` is 1. The k-th shifted bit becomes configuration bit k. AND bit index = term*2*NUM_IN + 2*input + polarity. OR bit index = AND_BITS + output*TERMS + term. With the defaults in full mode, AND_BITS = 96 and the total is 128 bits.
- R5: `dout` is 0 from reset until a clock edge samples `cfgDone` = 1 with `cfgShift` = 0. Any edge with `cfgShift` = 1 forces `dout` back to 0 until the next such `cfgDone`.
- R6: In full mode (`MODE_FULL`), with the array armed, each output equals the OR of the connected products, for every input pattern.
- R7: In fixed-OR mode (`MODE_FIXOR`), only the AND bits are loaded (96 by default). Output o is the OR of product lines o*T .. o*T+T-1, where T = NUM_TERM/NUM_OUT.
- R8: In fixed-minterm mode (`MODE_MINTERM`), the product lines are the 2^NUM_IN minterms, and exactly one is active: line number = `din`. Only OR bits are loaded (256 by default), and output o = OR bit o*2^NUM_IN + `din`.
- R9: An active-low `rstN` clears every configuration bit and disarms the outputs. Arming after reset without reloading leaves `dout` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain and arm state |
| rstN | input | 1 | Asynchronous active-low reset |
| din | input | NUM_IN | Primary logic inputs |
| cfgData | input | 1 | Serial configuration bit |
| cfgShift | input | 1 | Shift `cfgData` into the chain on this edge |
| cfgDone | input | 1 | Arm the outputs (ignored while shifting) |
| dout | output | NUM_OUT | Sum-of-products outputs, 0 while unarmed |

## Verification
The assertions assume that `cfgShift`, `cfgData` and `cfgDone` are known, synchronous levels that change only away from the rising edge. They also assume the chain image is meaningful only after exactly the full configuration length of shifts. The stimulus changes every control and data input on the falling edge and always shifts the complete bit count for the mode under test. It also holds `din` at a known value throughout. One case shifts a single extra bit on purpose, to exercise the disarm rule, and the bench expects zeros only where the requirements guarantee them.

// File: rtl/sop_fabric_pkg.sv
package sop_fabric_pkg;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_FIXOR   = 2'd1,
    MODE_MINTERM = 2'd2
  } fab_mode_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic outEnable;
  } fab_strobe_t;

  function automatic int termCount(fab_mode_e m, int nIn, int nTerm);
    return (m == MODE_MINTERM) ? (1 << nIn) : nTerm;
  endfunction

  function automatic int andBitCount(fab_mode_e m, int nIn, int nTerm);
    return (m == MODE_MINTERM) ? 0 : nTerm * 2 * nIn;
  endfunction

  function automatic int orBitCount(fab_mode_e m, int nOut, int nTerms);
    return (m == MODE_FIXOR) ? 0 : nOut * nTerms;
  endfunction

endpackage

// File: rtl/sop_fabric_ctrl.sv
module sop_fabric_ctrl
  import sop_fabric_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgData,
  input  logic        cfgShift,
  input  logic        cfgDone,
  output fab_strobe_t strobes
);

  logic armed;

  // Shifting has priority over arming: a partly loaded image never drives dout.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         armed <= 1'b0;
    else if (cfgShift) armed <= 1'b0;
    else if (cfgDone)  armed <= 1'b1;
  end

  always_comb begin
    strobes.shiftEn   = cfgShift;
    strobes.shiftBit  = cfgData;
    strobes.outEnable = armed;
  end

endmodule

// File: rtl/sop_fabric_store.sv
module sop_fabric_store
  import sop_fabric_pkg::*;
#(
  parameter int CFG_BITS = 128
) (
  input  logic                clk,
  input  logic                rstN,
  input  fab_strobe_t         strobes,
  output logic [CFG_BITS-1:0] cfgBits
);

  logic unusedStrobe;
  assign unusedStrobe = strobes.outEnable;

  // New bits enter at the top; after CFG_BITS shifts the first bit sits at index 0.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cfgBits <= '0;
    else if (strobes.shiftEn) cfgBits <= {strobes.shiftBit, cfgBits[CFG_BITS-1:1]};
  end

endmodule

// File: rtl/sop_fabric_and.sv
module sop_fabric_and
  import sop_fabric_pkg::*;
#(
  parameter int        NUM_IN = 6,
  parameter int        NTERMS = 8,
  parameter int        ANDW   = 96,
  parameter fab_mode_e MODE   = MODE_FULL
) (
  input  logic [NUM_IN-1:0] din,
  input  logic [ANDW-1:0]   andCfg,
  output logic [NTERMS-1:0] termLines
);

  localparam int LITS = 2 * NUM_IN;

  generate
    if (MODE == MODE_MINTERM) begin : g_decoder
      logic unusedCfg;
      assign unusedCfg = ^andCfg;
      for (genvar t = 0; t < NTERMS; t++) begin : g_min
        assign termLines[t] = (din == NUM_IN'(t));
      end
    end else begin : g_prog
      logic [LITS-1:0] lits;
      for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
        assign lits[2*i]   = din[i];
        assign lits[2*i+1] = ~din[i];
      end
      for (genvar t = 0; t < NTERMS; t++) begin : g_term
        logic [LITS-1:0] conn;
        assign conn = andCfg[t*LITS +: LITS];
        // open crosspoints pass 1; a term with no connections is held at 0
        assign termLines[t] = (|conn) & (&(~conn | lits));
      end
    end
  endgenerate

endmodule

// File: rtl/sop_fabric_or.sv
module sop_fabric_or
  import sop_fabric_pkg::*;
#(
  parameter int        NUM_OUT = 4,
  parameter int        NTERMS  = 8,
  parameter int        ORW     = 32,
  parameter fab_mode_e MODE    = MODE_FULL
) (
  input  logic [NTERMS-1:0]  termLines,
  input  logic [ORW-1:0]     orCfg,
  input  fab_strobe_t        strobes,
  output logic [NUM_OUT-1:0] dout
);

  logic [NUM_OUT-1:0] rawOut;
  logic               unusedStrobe;
  assign unusedStrobe = strobes.shiftEn ^ strobes.shiftBit;

  generate
    if (MODE == MODE_FIXOR) begin : g_fixed
      localparam int TPO = NTERMS / NUM_OUT;
      logic unusedCfg;
      assign unusedCfg = ^orCfg;
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_grp
        assign rawOut[o] = |termLines[o*TPO +: TPO];
      end
    end else begin : g_prog
      for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
        assign rawOut[o] = |(termLines & orCfg[o*NTERMS +: NTERMS]);
      end
    end
  endgenerate

  assign dout = strobes.outEnable ? rawOut : '0;

endmodule

// File: rtl/sop_fabric.sv
module sop_fabric
  import sop_fabric_pkg::*;
#(
  parameter int        NUM_IN   = 6,
  parameter int        NUM_TERM = 8,
  parameter int        NUM_OUT  = 4,
  parameter fab_mode_e MODE     = MODE_FULL
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  din,
  input  logic               cfgData,
  input  logic               cfgShift,
  input  logic               cfgDone,
  output logic [NUM_OUT-1:0] dout
);

  localparam int NTERMS   = termCount(MODE, NUM_IN, NUM_TERM);
  localparam int AND_BITS = andBitCount(MODE, NUM_IN, NUM_TERM);
  localparam int OR_BITS  = orBitCount(MODE, NUM_OUT, NTERMS);
  localparam int CFG_BITS = AND_BITS + OR_BITS;
  localparam int ANDW     = (AND_BITS > 0) ? AND_BITS : 1;
  localparam int ORW      = (OR_BITS > 0) ? OR_BITS : 1;

  fab_strobe_t         strobes;
  logic [CFG_BITS-1:0] cfgBits;
  logic [ANDW-1:0]     andCfg;
  logic [ORW-1:0]      orCfg;
  logic [NTERMS-1:0]   termLines;

  sop_fabric_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgData(cfgData),
    .cfgShift(cfgShift), .cfgDone(cfgDone), .strobes(strobes)
  );

  sop_fabric_store #(.CFG_BITS(CFG_BITS)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgBits(cfgBits)
  );

  generate
    if (AND_BITS > 0) begin : g_andSlice
      assign andCfg = cfgBits[AND_BITS-1:0];
    end else begin : g_andNone
      assign andCfg = '0;
    end
    if (OR_BITS > 0) begin : g_orSlice
      assign orCfg = cfgBits[AND_BITS +: OR_BITS];
    end else begin : g_orNone
      assign orCfg = '0;
    end
  endgenerate

  sop_fabric_and #(
    .NUM_IN(NUM_IN), .NTERMS(NTERMS), .ANDW(ANDW), .MODE(MODE)
  ) u_and (
    .din(din), .andCfg(andCfg), .termLines(termLines)
  );

  sop_fabric_or #(
    .NUM_OUT(NUM_OUT), .NTERMS(NTERMS), .ORW(ORW), .MODE(MODE)
  ) u_or (
    .termLines(termLines), .orCfg(orCfg), .strobes(strobes), .dout(dout)
  );

endmodule

// File: rtl/sop_fabric_chk.sv
module sop_fabric_chk
  import sop_fabric_pkg::*;
#(
  parameter int        NUM_OUT  = 4,
  parameter int        NTERMS   = 8,
  parameter int        CFG_BITS = 128,
  parameter fab_mode_e MODE     = MODE_FULL
) (
  input logic                clk,
  input logic                rstN,
  input logic                cfgData,
  input logic                cfgShift,
  input logic [NUM_OUT-1:0]  dout,
  input logic [NTERMS-1:0]   termLines,
  input logic [CFG_BITS-1:0] cfgBits
);

  // R5
  shift_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgShift |=> (dout == '0));

  // R9
  reset_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dout == '0));

  // R9
  reset_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgBits == '0));

  // R3
  out_needs_term_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|dout) |-> (|termLines));

  // R4
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgShift |=> $stable(cfgBits));

  // R4
  shift_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgShift |=> (cfgBits[CFG_BITS-1] == $past(cfgData)));

  generate
    if (MODE == MODE_MINTERM) begin : g_min
      // R8
      onehot_term_chk: assert property (@(posedge clk) disable iff (!rstN)
        $countones(termLines) == 1);
    end
  endgenerate

endmodule

bind sop_fabric sop_fabric_chk #(
  .NUM_OUT(NUM_OUT), .NTERMS(NTERMS), .CFG_BITS(CFG_BITS), .MODE(MODE)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgData(cfgData), .cfgShift(cfgShift),
  .dout(dout), .termLines(termLines), .cfgBits(cfgBits)
);

// File: tb/sop_fabric_bench.sv
module sop_fabric_bench;
  import sop_fabric_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 6;
  localparam int NT = 8;
  localparam int NO = 4;
  localparam int ANDB  = NT * 2 * NI;      // 96
  localparam int FULLB = ANDB + NO * NT;   // 128
  localparam int MINTB = NO * (1 << NI);   // 256

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NI-1:0] din = '0;
  logic          cfgData  [3];
  logic          cfgShift [3];
  logic          cfgDone  [3];
  logic [NO-1:0] dout     [3];
  logic [255:0]  img      [3];

  int  vecs = 0;
  int  errs = 0;
  bit  finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sop_fabric #(.MODE(MODE_FULL)) u_sop_fabric (
    .clk(clk), .rstN(rstN), .din(din), .cfgData(cfgData[0]),
    .cfgShift(cfgShift[0]), .cfgDone(cfgDone[0]), .dout(dout[0]));

  sop_fabric #(.MODE(MODE_FIXOR)) u_sop_fabric_fixor (
    .clk(clk), .rstN(rstN), .din(din), .cfgData(cfgData[1]),
    .cfgShift(cfgShift[1]), .cfgDone(cfgDone[1]), .dout(dout[1]));

  sop_fabric #(.MODE(MODE_MINTERM)) u_sop_fabric_mint (
    .clk(clk), .rstN(rstN), .din(din), .cfgData(cfgData[2]),
    .cfgShift(cfgShift[2]), .cfgDone(cfgDone[2]), .dout(dout[2]));

  function automatic int cfgLen(int d);
    return (d == 0) ? FULLB : (d == 1) ? ANDB : MINTB;
  endfunction

  // Reference sum-of-products built from the requirement text.
  function automatic logic [NO-1:0] model(int d, logic [NI-1:0] x);
    logic [63:0]   t;
    logic [NO-1:0] r;
    logic [11:0]   c;
    logic          ok;
    t = '0;
    r = '0;
    if (d == 2) begin
      t[x] = 1'b1;
      for (int o = 0; o < NO; o++) r[o] = |(t & img[2][o*64 +: 64]);
    end else begin
      for (int tt = 0; tt < NT; tt++) begin
        c  = img[d][tt*12 +: 12];
        ok = (c != 0);
        for (int i = 0; i < NI; i++) begin
          if (c[2*i]   && !x[i]) ok = 1'b0;
          if (c[2*i+1] &&  x[i]) ok = 1'b0;
        end
        t[tt] = ok;
      end
      for (int o = 0; o < NO; o++) begin
        if (d == 0) r[o] = |(t[7:0] & img[0][ANDB + o*8 +: 8]);
        else        r[o] = t[2*o] | t[2*o+1];
      end
    end
    return r;
  endfunction

  task automatic check(int d, logic [NO-1:0] exp, string tag);
    vecs++;
    if (dout[d] !== exp) begin
      errs++;
      $display("FAIL %s dut%0d din=%0d actual=%h expected=%h", tag, d, din, dout[d], exp);
    end
  endtask

  task automatic applyDin(logic [NI-1:0] v);
    @(negedge clk);
    din = v;
    #1;
  endtask

  task automatic sweepModel(int d, string tag);
    for (int x = 0; x < 64; x++) begin
      applyDin(NI'(x));
      check(d, model(d, NI'(x)), tag);
    end
  endtask

  task automatic sweepZero(int d, string tag);
    for (int x = 0; x < 64; x += 7) begin
      applyDin(NI'(x));
      check(d, '0, tag);
    end
  endtask

  task automatic loadCfg(int d, bit arm);
    for (int k = 0; k < cfgLen(d); k++) begin
      @(negedge clk);
      cfgData[d]  = img[d][k];
      cfgShift[d] = 1'b1;
    end
    @(negedge clk);
    cfgShift[d] = 1'b0;
    cfgData[d]  = 1'b0;
    if (arm) begin
      cfgDone[d] = 1'b1;
      @(negedge clk);
      cfgDone[d] = 1'b0;
    end
  endtask

  task automatic randAnd(int d);
    for (int k = 0; k < ANDB; k++) img[d][k] = ($urandom_range(0, 5) == 0);
  endtask

  task automatic testReset();
    // R9 R5: outputs zero after reset, before any arming
    for (int d = 0; d < 3; d++) sweepZero(d, "R9");
  endtask

  task automatic testArmGate();
    img[0] = '0;
    randAnd(0);
    for (int k = ANDB; k < FULLB; k++) img[0][k] = $urandom_range(0, 1);
    loadCfg(0, 1'b0);
    sweepZero(0, "R5");       // loaded but not armed
    @(negedge clk);
    cfgDone[0] = 1'b1;
    @(negedge clk);
    cfgDone[0] = 1'b0;
    sweepModel(0, "R5");      // armed now
    @(negedge clk);
    cfgShift[0] = 1'b1;
    cfgData[0]  = 1'b1;
    @(negedge clk);
    cfgShift[0] = 1'b0;
    cfgData[0]  = 1'b0;
    sweepZero(0, "R5");       // a shift disarms
  endtask

  task automatic testFullRandom();
    // R1 R6: random programmed arrays against the reference
    for (int n = 0; n < 4; n++) begin
      img[0] = '0;
      randAnd(0);
      for (int k = ANDB; k < FULLB; k++) img[0][k] = $urandom_range(0, 1);
      loadCfg(0, 1'b1);
      sweepModel(0, "R6");
    end
  endtask

  task automatic testEmptyTerms();
    // R2: term0 empty -> out0 never asserts; term1 = ~x3 -> out1; term2 = x1 & ~x1 -> out2 is 0
    img[0] = '0;
    img[0][1*12 + 2*3 + 1] = 1'b1;
    img[0][2*12 + 2*1]     = 1'b1;
    img[0][2*12 + 2*1 + 1] = 1'b1;
    img[0][ANDB + 0*8 + 0] = 1'b1;
    img[0][ANDB + 1*8 + 1] = 1'b1;
    img[0][ANDB + 2*8 + 2] = 1'b1;
    loadCfg(0, 1'b1);
    for (int x = 0; x < 64; x++) begin
      applyDin(NI'(x));
      check(0, {2'b00, ~x[3], 1'b0}, "R2");
    end
  endtask

  task automatic testOrOpen();
    // R3: programmed products, no OR connections
    img[0] = '0;
    randAnd(0);
    loadCfg(0, 1'b1);
    sweepZero(0, "R3");
    img[2] = '0;
    loadCfg(2, 1'b1);
    sweepZero(2, "R3");
  endtask

  task automatic testOrder();
    // R4: AND bit 2*12+8 (term2, input4, true) and OR bit 96+3*8+2 (out3, term2)
    img[0] = '0;
    img[0][32]  = 1'b1;
    img[0][122] = 1'b1;
    loadCfg(0, 1'b1);
    for (int x = 0; x < 64; x++) begin
      applyDin(NI'(x));
      check(0, {x[4], 3'b000}, "R4");
    end
  endtask

  task automatic testFixedOr();
    // R7: term5 = ~x0 feeds group 2 only
    img[1] = '0;
    img[1][5*12 + 1] = 1'b1;
    loadCfg(1, 1'b1);
    for (int x = 0; x < 64; x++) begin
      applyDin(NI'(x));
      check(1, {1'b0, ~x[0], 2'b00}, "R7");
    end
    for (int n = 0; n < 3; n++) begin
      img[1] = '0;
      randAnd(1);
      loadCfg(1, 1'b1);
      sweepModel(1, "R7");
    end
  endtask

  task automatic testMinterm();
    // R8: only OR bit 1*64+37 set -> out1 only at din 37
    img[2] = '0;
    img[2][64 + 37] = 1'b1;
    loadCfg(2, 1'b1);
    for (int x = 0; x < 64; x++) begin
      applyDin(NI'(x));
      check(2, (x == 37) ? 4'b0010 : 4'b0000, "R8");
    end
    for (int n = 0; n < 2; n++) begin
      for (int k = 0; k < MINTB; k++) img[2][k] = $urandom_range(0, 1);
      loadCfg(2, 1'b1);
      sweepModel(2, "R8");
    end
  endtask

  task automatic testMidReset();
    // R9: reset clears images; re-arming without reload keeps dout at 0
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    for (int d = 0; d < 3; d++) sweepZero(d, "R9");
    @(negedge clk);
    for (int d = 0; d < 3; d++) cfgDone[d] = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++) cfgDone[d] = 1'b0;
    for (int d = 0; d < 3; d++) sweepZero(d, "R9");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  initial begin
    for (int d = 0; d < 3; d++) begin
      cfgData[d]  = 1'b0;
      cfgShift[d] = 1'b0;
      cfgDone[d]  = 1'b0;
      img[d]      = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testArmGate();
    testFullRandom();
    testEmptyTerms();
    testOrOpen();
    testOrder();
    testFixedOr();
    testMinterm();
    testMidReset();
    finish();
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

endmodule